// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block sits between a processor's load/store port and a word-serial backing memory. It holds recently used 32-bit words in a small direct-mapped array of lines. The processor holds a request, with a write enable, an address and store data, until the block raises ready for one cycle. A request that hits finishes in the cycle it is presented. A miss makes the block drive the memory port one word at a time. A read holds the memory read strobe for the read latency, and a write holds the write strobe for the write latency.

Two parameters fix the policies, and each can be set without the other. The write policy is write-back or write-through. The store-miss policy is allocate or no-allocate. Each line keeps a valid bit and a dirty bit. Two outputs report the lookup: a hit flag, and a flag that the line a miss would displace holds modified data.

Top module: `dcache_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every line is invalid and clean. With no request, ready, hit, mem_rd and mem_wr are all low, and the first access to any address misses.
- R2: Byte address bits [1:0] are ignored, [4:2] pick the word in a line, [6:5] pick one of 4 lines and [9:7] form the tag. hit is high while a request is presented and the indexed line is valid with an equal tag.
- R3: A load that hits returns the word with ready high in the same cycle it is presented (latency 1).
- R4: A load miss refills the 8-word line. Each word holds mem_rd for 5 cycles (40 read cycles in total), and ready follows one cycle after the refill (latency 42 with a clean victim).
- R5: With write-back, a miss that allocates over a valid dirty line raises victim_dirty and first writes the 8 victim words to the victim's address at 3 cycles each (24 write cycles), then refills (latency 66 for a load).
- R6: With write-back, a store hit updates the cache and marks the line dirty. It finishes in 1 cycle with no memory write, and memory gets the data only on eviction.
- R7: With write-through, a store hit updates the cache word and writes that one word to memory in 3 cycles, with ready in the last (latency 4). Lines never become dirty, so victim_dirty stays low.
- R8: With no-write-allocate, a store miss writes only that word to memory (latency 4) and leaves the cache contents, tags and valid bits unchanged.
- R9: With write-allocate, a store miss refills the line as a load would and then applies the store as a hit: latency 42 with write-back, or 45 with write-through.
- R10: A load always returns the most recent value stored to that address under every policy pair.
- R11: mem_rd and mem_wr are never high together, and mem_addr is held steady through each word's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 10 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with ready |
| hit | output | 1 | Request hits a valid line |
| victim_dirty | output | 1 | Request misses and the indexed line is valid and dirty |
| mem_rd | output | 1 | Memory read strobe, held per word |
| mem_wr | output | 1 | Memory write strobe, held per word |
| mem_addr | output | 10 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, sampled in the last latency cycle |

## Verification
The case that needs care is a dirty eviction followed by a refill of the same line. The last write-back cycle reads the old data, and the next cycle starts writing new words into that same line from memory. A store that allocates over a dirty line adds a third step, the store write and dirty marking, right after the refill. The bench provokes these cases with loads and stores to addresses that share an index but differ in tag, run against four instances that cover every policy pair. For each access it judges the latency, the hit and victim flags, the read and write strobe cycle counts and the returned data, and it compares the whole backing memory with a model that applies each policy arithmetically.

// File: rtl/dc_pkg.sv
// Package: shared types for the data cache controller.
// Assumes nothing beyond IEEE 1800-2017.
package dc_pkg;

    // Controller states: idle/lookup, victim write-back, line refill, single-word write.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_WORD  = 2'd3
    } dc_state_e;

    // Larger of two integers, used to size the latency counter.
    function automatic int dc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dc_tag_store.sv
// Module: per-line valid, dirty and tag storage.
// All updates target the currently indexed line. A refill sets valid and clears dirty.
// Assumes fill_en and dirty_set are never high together.
module dc_tag_store #(
    parameter int LINES = 4,
    parameter int TAG_W = 3,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_set,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Status bits: cleared by reset, set by refill, dirty marked by store hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (dirty_set) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // Tag array: written only when a line is refilled.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

    // A dirty line must always be valid (R5).
    for (genvar i = 0; i < LINES; i++) begin : g_chk
        a_r5_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            dirty_q[i] |-> valid_q[i]);
    end
endmodule

// File: rtl/dc_data_store.sv
// Module: cache data array with one write port and one combinational read port.
// The array is not reset; the valid bits guard its contents.
module dc_data_store #(
    parameter int LINES  = 4,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [LINES*WORDS];

    // Word write from either the refill path or the store path.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{wr_idx, wr_word}] <= wr_data;
    end

    assign rd_data = mem_q[{rd_idx, rd_word}];
endmodule

// File: rtl/dc_seq.sv
// Module: control sequencer for the data cache.
// It decides hit, miss, write-back, refill and single-word write actions, and counts
// memory latency per word and words per line.
// Assumes the processor holds its request stable until ready.
module dc_seq
    import dc_pkg::*;
#(
    parameter int WORDS       = 8,
    parameter int RD_LAT      = 5,
    parameter int WR_LAT      = 3,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1,
    localparam int WSEL_W = $clog2(WORDS),
    localparam int LAT_W  = $clog2(dc_max(RD_LAT, WR_LAT) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              hit,
    input  logic              line_valid,
    input  logic              line_dirty,
    output dc_state_e         state,
    output logic [WSEL_W-1:0] word_cnt,
    output logic              lat_mid,
    output logic              ready,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              fill_word_we,
    output logic              fill_done,
    output logic              store_we,
    output logic              dirty_set
);
    dc_state_e        nxt;
    logic [LAT_W-1:0] lat_cnt;
    logic             lat_last;
    logic             word_last;

    assign lat_last  = (state == ST_FILL) ? (lat_cnt == LAT_W'(RD_LAT - 1))
                                          : (lat_cnt == LAT_W'(WR_LAT - 1));
    assign word_last = (word_cnt == WSEL_W'(WORDS - 1));
    assign lat_mid   = (lat_cnt != '0);

    // Next state and strobes for the current state.
    always_comb begin
        nxt          = state;
        ready        = 1'b0;
        mem_rd       = 1'b0;
        mem_wr       = 1'b0;
        fill_word_we = 1'b0;
        fill_done    = 1'b0;
        store_we     = 1'b0;
        dirty_set    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req) begin
                    if (hit) begin
                        store_we  = we;
                        dirty_set = we && WRITE_BACK;
                        ready     = !we || WRITE_BACK;
                        if (we && !WRITE_BACK) nxt = ST_WORD;
                    end else if (we && !WRITE_ALLOC) begin
                        nxt = ST_WORD;
                    end else if (WRITE_BACK && line_valid && line_dirty) begin
                        nxt = ST_WBACK;
                    end else begin
                        nxt = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_wr = 1'b1;
                if (lat_last && word_last) nxt = ST_FILL;
            end
            ST_FILL: begin
                mem_rd       = 1'b1;
                fill_word_we = lat_last;
                if (lat_last && word_last) begin
                    fill_done = 1'b1;
                    nxt       = ST_IDLE;
                end
            end
            default: begin
                mem_wr = 1'b1;
                if (lat_last) begin
                    ready = 1'b1;
                    nxt   = ST_IDLE;
                end
            end
        endcase
    end

    // State register with latency and word counters that restart on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lat_cnt  <= '0;
            word_cnt <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) begin
                lat_cnt  <= '0;
                word_cnt <= '0;
            end else if (state != ST_IDLE) begin
                if (lat_last) begin
                    lat_cnt  <= '0;
                    word_cnt <= word_cnt + WSEL_W'(1);
                end else begin
                    lat_cnt <= lat_cnt + LAT_W'(1);
                end
            end
        end
    end

    // Memory port never reads and writes at once (R11).
    a_r11_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // Completion is only signalled to a live request (R3).
    a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> req);
    // An eviction is always followed by a refill, never by idle (R5).
    a_r5_wback_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WBACK) |=> (state == ST_WBACK || state == ST_FILL));
    // A refill completes by returning to idle for the hit lookup (R4).
    a_r4_fill_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |=> (state == ST_IDLE));
endmodule

// File: rtl/dcache_ctrl.sv
// Module: direct-mapped data cache controller (top).
// It splits the address into byte, word, index and tag fields, forms hit and victim flags,
// and steers the data array and the memory port from the sequencer's strobes.
// Assumes one outstanding request, held stable until ready.
module dcache_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int LINES       = 4,
    parameter int WORDS       = 8,
    parameter int RD_LAT      = 5,
    parameter int WR_LAT      = 3,
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              hit,
    output logic              victim_dirty,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;

    logic [WSEL_W-1:0] cpu_word;
    logic [IDX_W-1:0]  cpu_idx;
    logic [TAG_W-1:0]  cpu_tag;
    logic              line_valid, line_dirty, tag_match;
    logic [TAG_W-1:0]  line_tag;
    dc_state_e         state;
    logic [WSEL_W-1:0] word_cnt;
    logic              lat_mid;
    logic              fill_word_we, fill_done, store_we, dirty_set;
    logic [WSEL_W-1:0] arr_rd_word;
    logic [DATA_W-1:0] arr_rd_data;
    logic              unused_byte_bits;

    assign cpu_word         = cpu_addr[BYTE_W +: WSEL_W];
    assign cpu_idx          = cpu_addr[BYTE_W + WSEL_W +: IDX_W];
    assign cpu_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
    assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

    assign tag_match    = line_valid && (line_tag == cpu_tag);
    assign hit          = cpu_req && tag_match;
    assign victim_dirty = cpu_req && !tag_match && line_valid && line_dirty;

    dc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (cpu_idx),
        .fill_en    (fill_done),
        .fill_tag   (cpu_tag),
        .dirty_set  (dirty_set),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    dc_seq #(
        .WORDS(WORDS), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT),
        .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (cpu_req),
        .we           (cpu_we),
        .hit          (hit),
        .line_valid   (line_valid),
        .line_dirty   (line_dirty),
        .state        (state),
        .word_cnt     (word_cnt),
        .lat_mid      (lat_mid),
        .ready        (cpu_ready),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .fill_word_we (fill_word_we),
        .fill_done    (fill_done),
        .store_we     (store_we),
        .dirty_set    (dirty_set)
    );

    // Eviction walks the line by counter; all other reads use the request's word.
    assign arr_rd_word = (state == ST_WBACK) ? word_cnt : cpu_word;

    dc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (fill_word_we || store_we),
        .wr_idx  (cpu_idx),
        .wr_word (fill_word_we ? word_cnt : cpu_word),
        .wr_data (fill_word_we ? mem_rdata : cpu_wdata),
        .rd_idx  (cpu_idx),
        .rd_word (arr_rd_word),
        .rd_data (arr_rd_data)
    );

    assign cpu_rdata = arr_rd_data;

    // Memory address: victim line on eviction, requested line on refill, request word otherwise.
    always_comb begin
        case (state)
            ST_WBACK: mem_addr = {line_tag, cpu_idx, word_cnt, {BYTE_W{1'b0}}};
            ST_FILL:  mem_addr = {cpu_tag, cpu_idx, word_cnt, {BYTE_W{1'b0}}};
            default:  mem_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
        endcase
    end

    assign mem_wdata = (state == ST_WBACK) ? arr_rd_data : cpu_wdata;

    // Address held through each word's latency (R11).
    a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lat_mid |-> $stable(mem_addr));
    // Write-through never reports a dirty victim (R7).
    a_r7_no_dirty_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK == 1'b0) |-> !victim_dirty);
    // A write-back store hit leaves the memory port quiet in the next cycle (R6).
    a_r6_wb_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK && state == ST_IDLE && hit && cpu_we) |=> !mem_wr);
    // A dirty victim flag only appears without a hit (R2).
    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && victim_dirty));
endmodule

// File: tb/dcache_ctrl_tb.sv
// Bench: four instances cover every write/allocate policy pair. Each has its own
// backing memory, and a per-lane arithmetic model predicts latency, flags, data and memory.
module dcache_ctrl_tb;
    localparam int NL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_s [NL];
    logic        we_s  [NL];
    logic [9:0]  addr_s[NL];
    logic [31:0] wd_s  [NL];
    logic        rdy_s [NL];
    logic [31:0] rdat_s[NL];
    logic        hit_s [NL];
    logic        vd_s  [NL];
    logic        mrd_s [NL];
    logic        mwr_s [NL];
    logic [9:0]  maddr_s[NL];
    logic [31:0] mwd_s [NL];
    logic [31:0] mrdat_s[NL];

    logic [31:0] bmem [NL][256];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Lane g: write-back when g >= 2, write-allocate when g is odd.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        dcache_ctrl #(.WRITE_BACK(g >= 2), .WRITE_ALLOC(g % 2 == 1)) u_dut (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(req_s[g]), .cpu_we(we_s[g]), .cpu_addr(addr_s[g]), .cpu_wdata(wd_s[g]),
            .cpu_ready(rdy_s[g]), .cpu_rdata(rdat_s[g]), .hit(hit_s[g]), .victim_dirty(vd_s[g]),
            .mem_rd(mrd_s[g]), .mem_wr(mwr_s[g]), .mem_addr(maddr_s[g]), .mem_wdata(mwd_s[g]),
            .mem_rdata(mrdat_s[g])
        );
        assign mrdat_s[g] = bmem[g][maddr_s[g][9:2]];
    end

    function automatic logic [31:0] pat(input int l, input int w);
        return {8'(l + 1), 8'h5A, 8'(w), 8'(255 - w)};
    endfunction

    // Backing memories: loaded with a pattern in reset, written while mem_wr is held.
    always @(posedge clk) begin
        for (int l = 0; l < NL; l++) begin
            if (!rst_n) begin
                for (int w = 0; w < 256; w++) bmem[l][w] <= pat(l, w);
            end else if (mwr_s[l]) begin
                bmem[l][maddr_s[l][9:2]] <= mwd_s[l];
            end
        end
    end

    logic [31:0] expm [NL][256];
    logic [31:0] tru  [NL][256];
    logic [31:0] cdat [NL][4][8];
    bit          vld  [NL][4];
    bit          drt  [NL][4];
    logic [2:0]  tgm  [NL][4];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access on lane l; model predicted first, then compared at the ports.
    task automatic access(input int l, input bit w, input logic [9:0] a, input logic [31:0] d);
        bit wb = (l >= 2);
        bit wa = (l % 2 == 1);
        logic [1:0] ix = a[6:5];
        logic [2:0] wo = a[4:2];
        logic [2:0] tg = a[9:7];
        logic [7:0] wi = a[9:2];
        bit hp = vld[l][ix] && (tgm[l][ix] == tg);
        bit vdp = !hp && vld[l][ix] && drt[l][ix];
        bit alloc = !hp && (!w || wa);
        bit wback = alloc && wb && vdp;
        bit single = w && (!wb || (!hp && !wa));
        int exp_lat, exp_rd, exp_wr, cyc, nrd, nwr;
        bit h0, v0, clash, img_ok;
        string lt;
        logic [31:0] got;

        if (hp) begin
            exp_lat = (w && !wb) ? 4 : 1;
            lt = !w ? "R3 latency" : (wb ? "R6 latency" : "R7 latency");
        end else if (!alloc) begin
            exp_lat = 4;
            lt = "R8 latency";
        end else begin
            exp_lat = 1 + (wback ? 24 : 0) + 40 + 1 + ((w && !wb) ? 3 : 0);
            lt = w ? "R9 latency" : (wback ? "R5 latency" : "R4 latency");
        end
        exp_rd = alloc ? 40 : 0;
        exp_wr = (wback ? 24 : 0) + (single ? 3 : 0);

        if (alloc) begin
            if (wback)
                for (int k = 0; k < 8; k++) expm[l][{tgm[l][ix], ix, 3'(k)}] = cdat[l][ix][k];
            for (int k = 0; k < 8; k++) cdat[l][ix][k] = expm[l][{tg, ix, 3'(k)}];
            vld[l][ix] = 1'b1;
            drt[l][ix] = 1'b0;
            tgm[l][ix] = tg;
        end
        if (w) begin
            tru[l][wi] = d;
            if (hp || alloc) begin
                cdat[l][ix][wo] = d;
                if (wb) drt[l][ix] = 1'b1;
                else    expm[l][wi] = d;
            end else begin
                expm[l][wi] = d;
            end
        end

        @(negedge clk);
        req_s[l] = 1'b1; we_s[l] = w; addr_s[l] = a; wd_s[l] = d;
        cyc = 0; nrd = 0; nwr = 0; clash = 1'b0; h0 = 1'b0; v0 = 1'b0;
        do begin
            if (cyc > 0) @(negedge clk);
            #1;
            cyc++;
            if (cyc == 1) begin h0 = hit_s[l]; v0 = vd_s[l]; end
            nrd += int'(mrd_s[l]);
            nwr += int'(mwr_s[l]);
            clash |= mrd_s[l] && mwr_s[l];
        end while (!rdy_s[l] && cyc < 400);
        got = rdat_s[l];
        @(negedge clk);
        req_s[l] = 1'b0; we_s[l] = 1'b0;
        #1;

        chk(cyc == exp_lat, lt, 32'(cyc), 32'(exp_lat));
        chk(h0 == hp, "R2 hit flag", 32'(h0), 32'(hp));
        chk(v0 == (vdp && wb), "R5 victim_dirty flag", 32'(v0), 32'(vdp && wb));
        chk(nrd == exp_rd, "R4 read strobe cycles", 32'(nrd), 32'(exp_rd));
        chk(nwr == exp_wr, wback ? "R5 write strobe cycles" : "R7 write strobe cycles",
            32'(nwr), 32'(exp_wr));
        chk(!clash, "R11 strobes exclusive", 32'(clash), 32'd0);
        if (!w) chk(got == tru[l][wi], "R10 load data", got, tru[l][wi]);
        img_ok = 1'b1;
        for (int k = 0; k < 256; k++) if (bmem[l][k] !== expm[l][k]) img_ok = 1'b0;
        chk(img_ok, (single && !hp && !wa) ? "R8 memory image" : (wb ? "R6 memory image" : "R7 memory image"),
            32'(img_ok), 32'd1);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < NL; l++) begin
            req_s[l] = 1'b0; we_s[l] = 1'b0; addr_s[l] = '0; wd_s[l] = '0;
            for (int w = 0; w < 256; w++) begin expm[l][w] = pat(l, w); tru[l][w] = pat(l, w); end
            for (int i = 0; i < 4; i++) begin vld[l][i] = 1'b0; drt[l][i] = 1'b0; tgm[l][i] = '0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: quiet ports after reset with no request.
        for (int l = 0; l < NL; l++)
            chk(!rdy_s[l] && !hit_s[l] && !mrd_s[l] && !mwr_s[l] && !vd_s[l], "R1 reset outputs",
                {28'd0, rdy_s[l], hit_s[l], mrd_s[l], mwr_s[l]}, 32'd0);

        for (int l = 0; l < NL; l++) begin
            // Directed corners: cold miss, hit, store hit, same-index conflicts, store miss.
            access(l, 1'b0, 10'h000, 32'h0);
            access(l, 1'b0, 10'h004, 32'h0);
            access(l, 1'b1, 10'h008, 32'hCAFE_0001);
            access(l, 1'b0, 10'h080, 32'h0);
            access(l, 1'b0, 10'h008, 32'h0);
            access(l, 1'b1, 10'h100, 32'hCAFE_0002);
            access(l, 1'b0, 10'h100, 32'h0);
            access(l, 1'b1, 10'h3FE, 32'hCAFE_0003);
            access(l, 1'b0, 10'h3FC, 32'h0);
            // Sweep: a stride that visits distinct words across all tags and lines.
            for (int i = 0; i < 160; i++) begin
                int w = (i * 53 + 7) % 256;
                access(l, (i % 3 == 0), 10'(w * 4), {16'(i), 16'(w)} ^ 32'hBEEF_0000);
            end
            // Read back one word of every tag and line.
            for (int k = 0; k < 32; k++) access(l, 1'b0, 10'(k * 32 + (k % 8) * 4), 32'h0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule